// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder

This block adds two 32-bit single-precision floating-point words and returns their rounded sum. Each word has a sign in bit 31, an 8-bit exponent field in bits 30:23 biased by 127, and a 23-bit fraction in bits 22:0. Every nonzero operand is normalized, so its significand is the fraction with a hidden leading 1, 24 bits in all. An operand whose exponent field is 0 is taken as zero. Exponent field 255 (infinity and not-a-number) and subnormal operands are not supported as inputs.

The operation runs in a two-stage pipeline. The first stage orders the operands by magnitude. It shifts the smaller significand right by the exponent difference, keeping guard, round and sticky bits, and then adds or subtracts according to the signs. The second stage normalizes left or right, adjusting the exponent, and rounds to nearest with ties to even. If rounding carries out of the significand, it renormalizes. It then checks the final exponent against the legal range of 1 to 254 (unbiased -126 to +127). The caller raises `in_valid` for one cycle per operation, may issue on every cycle, and receives `out_valid` exactly two cycles later.

Top module: `fp32_adder`

## Requirements
- R1: A word presented with `in_valid` high at a rising edge produces `out_valid` high for one cycle at the second rising edge after it. `out_valid` is low at all other times, including during and right after reset. Back-to-back issues return in issue order.
- R2: When the operand signs match, the significands are added. A carry out of the significand shifts the sum right one place and adds one to the exponent (1.0 + 1.0 = 0x40000000).
- R3: When the signs differ, the smaller magnitude is subtracted from the larger. The result is shifted left until its leading bit is 1, and the exponent drops by the same amount (0x3F000000 + 0xBEE00000 = 0x3D800000, exponent field 123).
- R4: The result takes the sign of the operand with the larger magnitude, and swapping the operands does not change the result.
- R5: Bits shifted out during alignment are kept as guard, round and sticky bits. Rounding is to nearest, with an exact halfway case going to the even significand (0x3F800000 + 0x33800000 = 0x3F800000; 0x3F800001 + 0x33800000 = 0x3F800002; 0x3F800000 + 0x33800001 = 0x3F800001).
- R6: If rounding carries out of the 24-bit significand, the result is renormalized to 1.0 times the next power of two (0x3FFFFFFF + 0x33800000 = 0x40000000).
- R7: An exact zero result, including from two zero operands of any signs, is encoded as 0x00000000 with no flag raised.
- R8: If the final exponent field would reach 255 or more, the result is infinity with the result sign (exponent field 255, fraction 0) and `out_ovf` is 1.
- R9: If the final exponent field of a nonzero result would be 0 or less, the result is flushed to a zero that keeps the result sign, and `out_unf` is 1. `out_ovf` and `out_unf` are 0 whenever `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands on `in_a`/`in_b` are valid this cycle |
| in_a | input | 32 | First single-precision operand |
| in_b | input | 32 | Second single-precision operand |
| out_valid | output | 1 | `out_sum` and flags are valid this cycle |
| out_sum | output | 32 | Rounded single-precision sum |
| out_ovf | output | 1 | Exponent overflow; `out_sum` is infinity |
| out_unf | output | 1 | Exponent underflow; `out_sum` is flushed to zero |

## Verification
Every result is due two rising edges after the edge that sampled its operands. The bench stores the due cycle number with each expected sum and flag pair, and reads results half a period after the edge that produced them. Any result that arrives early, late, out of order or missing is counted as a failure. The vectors are issued back to back and with idle gaps. They cover cancellation to zero, rounding ties in both directions, rounding carry-out, very large alignment shifts, and both exponent limits.

// File: rtl/fp32_adder.sv
module fp32_adder #(
  parameter int EW = 8,
  parameter int FW = 23
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [EW+FW:0]    in_a,
  input  logic [EW+FW:0]    in_b,
  output logic              out_valid,
  output logic [EW+FW:0]    out_sum,
  output logic              out_ovf,
  output logic              out_unf
);
  localparam int MW = FW + 1;
  localparam int XW = MW + 3;
  localparam int LW = $clog2(XW + 1);
  localparam int SW = EW + 2;
  localparam logic [EW-1:0] EMAX = '1;

  logic           a_big;
  logic [EW+FW:0] big, sml;
  logic [MW-1:0]  mb, ms;
  logic [EW-1:0]  diff;
  logic [XW-1:0]  ms_x, al;
  logic           lost;
  logic [XW:0]    sum;

  assign a_big = in_a[EW+FW-1:0] >= in_b[EW+FW-1:0];
  assign big   = a_big ? in_a : in_b;
  assign sml   = a_big ? in_b : in_a;
  assign mb    = (big[EW+FW-1:FW] != '0) ? {1'b1, big[FW-1:0]} : '0;
  assign ms    = (sml[EW+FW-1:FW] != '0) ? {1'b1, sml[FW-1:0]} : '0;
  assign diff  = big[EW+FW-1:FW] - sml[EW+FW-1:FW];
  assign ms_x  = {ms, 3'b000};

  always_comb begin
    if (diff >= EW'(XW)) begin
      al   = '0;
      lost = |ms;
    end else begin
      al   = ms_x >> diff;
      lost = |(ms_x & ((XW'(1) << diff) - XW'(1)));
    end
  end

  assign sum = (big[EW+FW] ^ sml[EW+FW])
             ? {1'b0, mb, 3'b000} - {1'b0, al[XW-1:1], al[0] | lost}
             : {1'b0, mb, 3'b000} + {1'b0, al[XW-1:1], al[0] | lost};

  logic          v1, sg1;
  logic [EW-1:0] e1;
  logic [XW:0]   s1;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      sg1 <= 1'b0;
      e1 <= '0;
      s1 <= '0;
    end else begin
      v1 <= in_valid;
      sg1 <= big[EW+FW];
      e1 <= big[EW+FW-1:FW];
      s1 <= sum;
    end
  end

  logic [LW-1:0]        lz;
  logic [XW-1:0]        nrm;
  logic signed [SW-1:0] e_n, e_r;
  logic                 up, zero, ovf, unf;
  logic [MW:0]          rm;
  logic [FW-1:0]        frac;
  logic [EW+FW:0]       res;

  always_comb begin
    lz = LW'(XW);
    for (int i = 0; i < XW; i++)
      if (s1[i]) lz = LW'(XW - 1 - i);
  end

  always_comb begin
    if (s1[XW]) begin
      nrm = {s1[XW:2], s1[1] | s1[0]};
      e_n = $signed({2'b00, e1}) + SW'(1);
    end else begin
      nrm = s1[XW-1:0] << lz;
      e_n = $signed({2'b00, e1}) - $signed(SW'(lz));
    end
  end

  assign up   = nrm[2] & (nrm[1] | nrm[0] | nrm[3]);
  assign rm   = {1'b0, nrm[XW-1:3]} + (MW+1)'(up);
  assign e_r  = e_n + $signed(SW'(rm[MW]));
  assign frac = rm[MW] ? rm[MW-1:1] : rm[FW-1:0];
  assign zero = (s1 == '0);
  assign ovf  = !zero && (e_r >= $signed(SW'(EMAX)));
  assign unf  = !zero && (e_r <= $signed(SW'(0)));

  always_comb begin
    if (zero)     res = '0;
    else if (ovf) res = {sg1, EMAX, {FW{1'b0}}};
    else if (unf) res = {sg1, {(EW+FW){1'b0}}};
    else          res = {sg1, e_r[EW-1:0], frac};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_sum <= '0;
      out_ovf <= 1'b0;
      out_unf <= 1'b0;
    end else begin
      out_valid <= v1;
      out_sum <= res;
      out_ovf <= v1 & ovf;
      out_unf <= v1 & unf;
    end
  end

  p_latency_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 out_valid);
  p_norm_lead_r3: assert property (@(posedge clk) disable iff (rst)
    (v1 && s1 != '0) |-> nrm[XW-1]);
  p_ovf_inf_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ovf) |-> (out_sum[EW+FW-1:FW] == EMAX && out_sum[FW-1:0] == '0 && !out_unf));
  p_unf_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_unf) |-> (out_sum[EW+FW-1:0] == '0));
  p_flags_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!out_ovf && !out_unf));
  p_exp_range_r2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ovf && !out_unf && out_sum[EW+FW-1:0] != '0)
      |-> (out_sum[EW+FW-1:FW] != '0 && out_sum[EW+FW-1:FW] != EMAX));
endmodule

// File: tb/fp32_adder_tb_top.sv
module fp32_adder_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_a = '0, in_b = '0;
  logic        out_valid, out_ovf, out_unf;
  logic [31:0] out_sum;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [33:0] exp_q[$];
  int          due_q[$];
  string       tag_q[$];

  fp32_adder dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_sum(out_sum), .out_ovf(out_ovf), .out_unf(out_unf)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic send(input logic [31:0] a, input logic [31:0] b,
                      input logic [31:0] s, input logic ov, input logic un,
                      input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_a = a;
    in_b = b;
    exp_q.push_back({s, ov, un});
    due_q.push_back(cyc + 2);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R1 unexpected result %h at cycle %0d, expected none", out_sum, cyc);
      end else begin
        logic [33:0] e;
        int d;
        string t;
        e = exp_q.pop_front();
        d = due_q.pop_front();
        t = tag_q.pop_front();
        if (d != cyc) begin
          errors++;
          $display("FAIL R1 (%s) result at cycle %0d, expected cycle %0d", t, cyc, d);
        end else if ({out_sum, out_ovf, out_unf} != e) begin
          errors++;
          $display("FAIL %s sum=%h ovf=%b unf=%b, expected sum=%h ovf=%b unf=%b",
                   t, out_sum, out_ovf, out_unf, e[33:2], e[1], e[0]);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset out_valid=%b, expected 0", out_valid);
    end
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 after reset out_valid=%b, expected 0", out_valid);
    end
    send(32'h3F000000, 32'hBEE00000, 32'h3D800000, 0, 0, "R3 0.5-0.4375");
    send(32'hBEE00000, 32'h3F000000, 32'h3D800000, 0, 0, "R4 swapped order");
    send(32'h3F800000, 32'h3F800000, 32'h40000000, 0, 0, "R2 1+1");
    send(32'h40A00000, 32'hBF400000, 32'h40880000, 0, 0, "R3 5-0.75");
    send(32'h3E800000, 32'hBF800000, 32'hBF400000, 0, 0, "R4 negative result");
    idle(3);
    send(32'h3F800000, 32'hBF800000, 32'h00000000, 0, 0, "R7 cancel");
    send(32'h80000000, 32'h80000000, 32'h00000000, 0, 0, "R7 -0 + -0");
    send(32'h00000000, 32'h40A00000, 32'h40A00000, 0, 0, "R7 zero operand");
    idle(1);
    send(32'h3F800000, 32'h33800000, 32'h3F800000, 0, 0, "R5 tie to even down");
    send(32'h3F800001, 32'h33800000, 32'h3F800002, 0, 0, "R5 tie to even up");
    send(32'h3F800000, 32'h33800001, 32'h3F800001, 0, 0, "R5 sticky above half");
    send(32'h7F000000, 32'h3F800000, 32'h7F000000, 0, 0, "R5 huge shift");
    send(32'h3F800000, 32'hA0000000, 32'h3F800000, 0, 0, "R5 sticky subtract");
    send(32'h3FFFFFFF, 32'h33800000, 32'h40000000, 0, 0, "R6 round carry");
    idle(2);
    send(32'h7F7FFFFF, 32'h7F7FFFFF, 32'h7F800000, 1, 0, "R8 overflow");
    send(32'hFF7FFFFF, 32'hFF7FFFFF, 32'hFF800000, 1, 0, "R8 negative overflow");
    send(32'h00C00000, 32'h80800000, 32'h00000000, 0, 1, "R9 underflow");
    send(32'h80C00000, 32'h00800000, 32'h80000000, 0, 1, "R9 negative underflow");
    send(32'h00800000, 32'h00800000, 32'h01000000, 0, 0, "R2 tiny doubled");
    idle(6);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R1 %0d results missing, expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired at cycle %0d, expected finish", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule